// File: doc/BRIEF.md
# Tick-Driven RTC Interrupt Emulator

This block recreates the three interrupt kinds of a classic real-time clock (once-per-second update, time-of-day alarm, and periodic at a power-of-two rate) from the match strobe of one comparator channel of a free-running timer. On every match it re-arms the comparator one increment ahead of the counter, decides which flags to raise, and pulses an interrupt strobe together with a flags word in the layout a status register of such a clock uses.

The base tick is the counter frequency divided by 64. Periodic rates up to 64 Hz are made by counting base ticks. Faster rates switch the comparator increment to the counter frequency divided by the rate, so every tick raises the periodic flag. When a tick is serviced late, the comparator is stepped forward one increment per cycle until it is ahead of the counter again. Each extra step is a lost tick, and it is credited to the periodic tick count. Calendar keeping and register access stay outside the block: the time of day, the alarm time and the enables arrive as plain inputs.

Top module: `rtc_tick_emu`

## Requirements
- R1: After reset, cmp_o is 0, cmp_en_o is 0, flags_o is 0 and irq_o is 0.
- R2: When at least one of upd_en_i, alm_en_i and per_en_i becomes set while none was set in the previous cycle, then on the next clock edge cmp_o becomes count_i plus the increment and cmp_en_o becomes 1. The increment is CNT_HZ/64, or CNT_HZ>>rate_log2_i in the fast periodic mode of R8.
- R3: A tick_i pulse seen while cmp_en_o is 1 and some enable is set starts a catch-up. Each cycle, cmp_o advances by one increment until the signed 32-bit value count_i minus cmp_o is zero or negative, so counter wraparound is handled. The flags of that tick appear on irq_o/flags_o one cycle after the first step, plus one cycle for each extra step.
- R4: With upd_en_i set, a tick raises the update flag (flags_o bit 4) when sec_i differs from the seconds value stored at the last update flag. The stored value, 0 after reset, is then replaced by sec_i.
- R5: With alm_en_i set, a tick raises the alarm flag (flags_o bit 5) when hour_i, min_i and sec_i all equal alm_hour_i, alm_min_i and alm_sec_i.
- R6: The periodic rate is 2^rate_log2_i Hz with rate_log2_i from 1 to 13. For codes up to 6, with per_en_i set, a tick counter counts ticks and the periodic flag (flags_o bit 6) is raised when it reaches 64>>rate_log2_i. The counter then returns to 0.
- R7: With per_en_i set, every extra catch-up step of R3 is added to the periodic tick counter before the tick itself is counted.
- R8: For rate_log2_i above 6 with per_en_i set, the increment is CNT_HZ>>rate_log2_i and every tick raises the periodic flag.
- R9: When a tick raises any flag, irq_o pulses for one cycle and flags_o holds the flags with bit 7 (interrupt pending) set and the value 1 in bits [15:8]. A tick raising no flag leaves irq_o low and sets flags_o to 0.
- R10: A tick seen while all three enables are clear sets cmp_en_o to 0 and raises no flag. While cmp_en_o is 0, tick_i is ignored and cmp_o holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Comparator match strobe from the timer channel |
| count_i | input | 32 | Free-running timer counter value |
| hour_i | input | TW | Current hour |
| min_i | input | TW | Current minute |
| sec_i | input | TW | Current second |
| upd_en_i | input | 1 | Update interrupt enable |
| alm_en_i | input | 1 | Alarm interrupt enable |
| per_en_i | input | 1 | Periodic interrupt enable |
| alm_hour_i | input | TW | Alarm hour |
| alm_min_i | input | TW | Alarm minute |
| alm_sec_i | input | TW | Alarm second |
| rate_log2_i | input | 4 | Periodic rate as log2 of frequency in Hz (1..13) |
| cmp_o | output | 32 | Next comparator value |
| cmp_en_o | output | 1 | Timer channel enable |
| flags_o | output | 16 | Flags word of the last serviced tick |
| irq_o | output | 1 | One-cycle interrupt strobe |

## Verification
Ticks are driven with the counter held just past, exactly equal to, and several increments beyond the comparator. These cases separate a single re-arm step from a multi-step catch-up, and the equality case shows whether the ahead test is strict. The periodic flag is exercised at 32 Hz (every second tick, with and without a lost tick credited), at 64 Hz and at 256 Hz, which tells the divide-down path apart from the fast-increment path. Update and alarm are tried with matching and non-matching seconds and times, alone and together. A final re-arm just below the 32-bit wrap shows that the ahead test is signed rather than unsigned.

// File: rtl/rtc_tick_emu_pkg.sv
package rtc_tick_emu_pkg;
    // Bit positions of the flags word (status-register layout)
    localparam int FLG_UPD  = 4;
    localparam int FLG_ALM  = 5;
    localparam int FLG_PER  = 6;
    localparam int FLG_PEND = 7;
    localparam int FLG_CNT_LSB = 8;

    localparam int BASE_LOG2 = 6;   // base tick = counter rate / 64
    localparam int RATE_MIN  = 1;
    localparam int RATE_MAX  = 13;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_CATCH = 1'b1
    } emu_state_e;
endpackage

// File: rtl/rtc_emu_rate.sv
module rtc_emu_rate
    import rtc_tick_emu_pkg::*;
#(
    parameter int CNT_HZ = 65536,
    parameter int PCW    = 16
) (
    input  logic           per_en_i,
    input  logic [3:0]     rate_log2_i,
    output logic [31:0]    delta_o,
    output logic [PCW-1:0] limit_o
);
    localparam logic [31:0] HZ_VEC     = 32'(CNT_HZ);
    localparam logic [31:0] BASE_DELTA = HZ_VEC >> BASE_LOG2;

    logic [3:0] kc;
    logic       fast;

    always_comb begin
        if (rate_log2_i < 4'(RATE_MIN))      kc = 4'(RATE_MIN);
        else if (rate_log2_i > 4'(RATE_MAX)) kc = 4'(RATE_MAX);
        else                                 kc = rate_log2_i;

        fast = per_en_i && (kc > 4'(BASE_LOG2));
        delta_o = fast ? (HZ_VEC >> kc) : BASE_DELTA;

        if (kc > 4'(BASE_LOG2)) limit_o = PCW'(1);
        else                    limit_o = PCW'(64) >> kc;
    end
endmodule

// File: rtl/rtc_emu_eval.sv
module rtc_emu_eval
    import rtc_tick_emu_pkg::*;
#(
    parameter int TW  = 8,
    parameter int PCW = 16
) (
    input  logic           upd_en_i,
    input  logic           alm_en_i,
    input  logic           per_en_i,
    input  logic [TW-1:0]  hour_i,
    input  logic [TW-1:0]  min_i,
    input  logic [TW-1:0]  sec_i,
    input  logic [TW-1:0]  alm_hour_i,
    input  logic [TW-1:0]  alm_min_i,
    input  logic [TW-1:0]  alm_sec_i,
    input  logic [TW-1:0]  prev_sec_i,
    input  logic [PCW-1:0] pcnt_i,
    input  logic [PCW-1:0] lost_i,
    input  logic [PCW-1:0] limit_i,
    output logic [15:0]    flags_o,
    output logic [PCW-1:0] pcnt_o,
    output logic [TW-1:0]  prev_sec_o
);
    logic [PCW+1:0] sum;
    logic [PCW-1:0] sum_sat;
    logic upd_hit, alm_hit, per_hit;

    always_comb begin
        sum     = (PCW+2)'(pcnt_i) + (PCW+2)'(lost_i) + (PCW+2)'(1);
        sum_sat = (sum > (PCW+2)'({PCW{1'b1}})) ? {PCW{1'b1}} : sum[PCW-1:0];

        upd_hit = upd_en_i && (sec_i != prev_sec_i);
        alm_hit = alm_en_i && (hour_i == alm_hour_i) && (min_i == alm_min_i)
                  && (sec_i == alm_sec_i);
        per_hit = per_en_i && (sum_sat >= limit_i);

        prev_sec_o = upd_hit ? sec_i : prev_sec_i;
        if (!per_en_i)    pcnt_o = pcnt_i;
        else if (per_hit) pcnt_o = '0;
        else              pcnt_o = sum_sat;

        flags_o = '0;
        flags_o[FLG_UPD] = upd_hit;
        flags_o[FLG_ALM] = alm_hit;
        flags_o[FLG_PER] = per_hit;
        if (upd_hit || alm_hit || per_hit) begin
            flags_o[FLG_PEND] = 1'b1;
            flags_o[15:FLG_CNT_LSB] = 8'd1;
        end
    end
endmodule

// File: rtl/rtc_tick_emu.sv
module rtc_tick_emu
    import rtc_tick_emu_pkg::*;
#(
    parameter int CNT_HZ = 65536,
    parameter int TW     = 8,
    parameter int PCW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [31:0]   count_i,
    input  logic [TW-1:0] hour_i,
    input  logic [TW-1:0] min_i,
    input  logic [TW-1:0] sec_i,
    input  logic          upd_en_i,
    input  logic          alm_en_i,
    input  logic          per_en_i,
    input  logic [TW-1:0] alm_hour_i,
    input  logic [TW-1:0] alm_min_i,
    input  logic [TW-1:0] alm_sec_i,
    input  logic [3:0]    rate_log2_i,
    output logic [31:0]   cmp_o,
    output logic          cmp_en_o,
    output logic [15:0]   flags_o,
    output logic          irq_o
);
    typedef struct packed {
        emu_state_e     state;
        logic [31:0]    cmp;
        logic           cmp_en;
        logic [PCW-1:0] steps;
        logic [PCW-1:0] pcnt;
        logic [TW-1:0]  prev_sec;
        logic           en_any;
        logic [15:0]    flags;
        logic           irq;
    } emu_regs_t;

    emu_regs_t r_q, r_d;

    logic [31:0]    delta;
    logic [PCW-1:0] limit;
    logic [15:0]    ev_flags;
    logic [PCW-1:0] ev_pcnt;
    logic [TW-1:0]  ev_prev;
    logic           en_any;
    logic [31:0]    step_cmp;
    logic [31:0]    gap;

    rtc_emu_rate #(.CNT_HZ(CNT_HZ), .PCW(PCW)) u_rate (
        .per_en_i    (per_en_i),
        .rate_log2_i (rate_log2_i),
        .delta_o     (delta),
        .limit_o     (limit)
    );

    rtc_emu_eval #(.TW(TW), .PCW(PCW)) u_eval (
        .upd_en_i   (upd_en_i),
        .alm_en_i   (alm_en_i),
        .per_en_i   (per_en_i),
        .hour_i     (hour_i),
        .min_i      (min_i),
        .sec_i      (sec_i),
        .alm_hour_i (alm_hour_i),
        .alm_min_i  (alm_min_i),
        .alm_sec_i  (alm_sec_i),
        .prev_sec_i (r_q.prev_sec),
        .pcnt_i     (r_q.pcnt),
        .lost_i     (r_q.steps),
        .limit_i    (limit),
        .flags_o    (ev_flags),
        .pcnt_o     (ev_pcnt),
        .prev_sec_o (ev_prev)
    );

    always_comb begin
        en_any   = upd_en_i | alm_en_i | per_en_i;
        step_cmp = r_q.cmp + delta;
        gap      = count_i - step_cmp;

        r_d        = r_q;
        r_d.irq    = 1'b0;
        r_d.en_any = en_any;

        case (r_q.state)
            ST_IDLE: begin
                if (en_any && !r_q.en_any) begin
                    r_d.cmp    = count_i + delta;
                    r_d.cmp_en = 1'b1;
                end else if (tick_i && r_q.cmp_en) begin
                    if (!en_any) begin
                        r_d.cmp_en = 1'b0;
                    end else begin
                        r_d.state = ST_CATCH;
                        r_d.steps = '0;
                    end
                end
            end
            ST_CATCH: begin
                r_d.cmp = step_cmp;
                if ($signed(gap) > 0) begin
                    if (r_q.steps != {PCW{1'b1}}) r_d.steps = r_q.steps + 1'b1;
                end else begin
                    r_d.state    = ST_IDLE;
                    r_d.flags    = ev_flags;
                    r_d.irq      = ev_flags[FLG_PEND];
                    r_d.pcnt     = ev_pcnt;
                    r_d.prev_sec = ev_prev;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmp_o    = r_q.cmp;
    assign cmp_en_o = r_q.cmp_en;
    assign flags_o  = r_q.flags;
    assign irq_o    = r_q.irq;
endmodule

// File: rtl/rtc_tick_emu_chk.sv
module rtc_tick_emu_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [31:0]   count_i,
    input logic [TW-1:0] hour_i,
    input logic [TW-1:0] min_i,
    input logic [TW-1:0] sec_i,
    input logic          upd_en_i,
    input logic          alm_en_i,
    input logic          per_en_i,
    input logic [TW-1:0] alm_hour_i,
    input logic [TW-1:0] alm_min_i,
    input logic [TW-1:0] alm_sec_i,
    input logic [31:0]   cmp_o,
    input logic          cmp_en_o,
    input logic [15:0]   flags_o,
    input logic          irq_o
);
    logic any_en;
    assign any_en = upd_en_i | alm_en_i | per_en_i;

    // R9: the strobe always carries pending bit and count of one
    a_r9_strobe_word: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags_o[7] && flags_o[15:8] == 8'd1));

    // R9: strobe lasts a single cycle
    a_r9_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R3: after a serviced tick the comparator is not behind the counter
    a_r3_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($signed(32'($past(count_i) - cmp_o)) <= 0));

    // R2: first enable arms the channel
    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (any_en && !$past(any_en) && !cmp_en_o) |=> cmp_en_o);

    // R10: disabled channel with no enables never interrupts
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en_o && !any_en) |=> (!irq_o && $stable(cmp_o)));

    // R5: alarm flag only when the time matched the alarm
    a_r5_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && flags_o[5]) |-> ($past(hour_i) == $past(alm_hour_i)
            && $past(min_i) == $past(alm_min_i) && $past(sec_i) == $past(alm_sec_i)));
endmodule

bind rtc_tick_emu rtc_tick_emu_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (count_i),
    .hour_i     (hour_i),
    .min_i      (min_i),
    .sec_i      (sec_i),
    .upd_en_i   (upd_en_i),
    .alm_en_i   (alm_en_i),
    .per_en_i   (per_en_i),
    .alm_hour_i (alm_hour_i),
    .alm_min_i  (alm_min_i),
    .alm_sec_i  (alm_sec_i),
    .cmp_o      (cmp_o),
    .cmp_en_o   (cmp_en_o),
    .flags_o    (flags_o),
    .irq_o      (irq_o)
);

// File: tb/rtc_tick_emu_test.sv
`timescale 1ns/1ps
module rtc_tick_emu_test;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [31:0] count_i = '0;
    logic [7:0]  hour_i = '0, min_i = '0, sec_i = '0;
    logic        upd_en_i = 1'b0, alm_en_i = 1'b0, per_en_i = 1'b0;
    logic [7:0]  alm_hour_i = 8'd1, alm_min_i = 8'd2, alm_sec_i = 8'd3;
    logic [3:0]  rate_log2_i = 4'd1;
    logic [31:0] cmp_o;
    logic        cmp_en_o;
    logic [15:0] flags_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rtc_tick_emu uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_i(count_i),
        .hour_i(hour_i), .min_i(min_i), .sec_i(sec_i),
        .upd_en_i(upd_en_i), .alm_en_i(alm_en_i), .per_en_i(per_en_i),
        .alm_hour_i(alm_hour_i), .alm_min_i(alm_min_i), .alm_sec_i(alm_sec_i),
        .rate_log2_i(rate_log2_i), .cmp_o(cmp_o), .cmp_en_o(cmp_en_o),
        .flags_o(flags_o), .irq_o(irq_o)
    );

    // Vector table: counter, enables {per,alm,upd}, time, rate, expected
    localparam logic [31:0] V_CNT [NV] = '{32'd2030, 32'd3050, 32'd6130, 32'd7150,
        32'd8170, 32'd10221, 32'd11240, 32'd11752, 32'd11760, 32'd12780, 32'd13800};
    localparam logic [2:0]  V_EN  [NV] = '{3'b001, 3'b001, 3'b001, 3'b101, 3'b101,
        3'b101, 3'b101, 3'b101, 3'b010, 3'b011, 3'b111};
    localparam logic [7:0]  V_MN  [NV] = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0,
        8'd0, 8'd0, 8'd2, 8'd2, 8'd2};
    localparam logic [7:0]  V_SC  [NV] = '{8'd5, 8'd5, 8'd6, 8'd6, 8'd6, 8'd6,
        8'd6, 8'd6, 8'd3, 8'd4, 8'd3};
    localparam logic [3:0]  V_K   [NV] = '{4'd1, 4'd1, 4'd1, 4'd5, 4'd5, 4'd5,
        4'd8, 4'd8, 4'd8, 4'd8, 4'd6};
    localparam logic [15:0] V_FLG [NV] = '{16'h0190, 16'h0000, 16'h0190, 16'h0000,
        16'h01C0, 16'h01C0, 16'h01C0, 16'h01C0, 16'h01A0, 16'h0190, 16'h01F0};
    localparam logic [31:0] V_CMP [NV] = '{32'd3048, 32'd4072, 32'd7144, 32'd8168,
        32'd9192, 32'd11240, 32'd11496, 32'd11752, 32'd12776, 32'd13800, 32'd14824};
    localparam int          V_LOST[NV] = '{0, 0, 2, 0, 0, 1, 0, 0, 0, 0, 0};
    localparam string       V_TAG [NV] = '{"R4", "R4", "R3", "R6", "R6", "R7",
        "R8", "R3", "R5", "R4", "R9"};

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Pulse a tick, then watch up to 16 cycles for the strobe
    task automatic do_tick(output bit seen, output int lat, output logic [15:0] flg);
        seen = 1'b0; lat = -1; flg = '0;
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (irq_o && !seen) begin
                seen = 1'b1; lat = i; flg = flags_o;
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen;
        int lat;
        logic [15:0] flg;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cmp", cmp_o, 32'd0);
        chk("R1", "cmp_en", {31'd0, cmp_en_o}, 32'd0);
        chk("R1", "flags", {16'd0, flags_o}, 32'd0);
        chk("R1", "irq", {31'd0, irq_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 arm on first enable: 1000 + 65536/64
        count_i = 32'd1000; hour_i = 8'd1; upd_en_i = 1'b1;
        @(negedge clk);
        chk("R2", "cmp", cmp_o, 32'd2024);
        chk("R2", "cmp_en", {31'd0, cmp_en_o}, 32'd1);

        for (int v = 0; v < NV; v++) begin
            count_i = V_CNT[v];
            {per_en_i, alm_en_i, upd_en_i} = V_EN[v];
            min_i = V_MN[v]; sec_i = V_SC[v]; rate_log2_i = V_K[v];
            @(negedge clk);
            do_tick(seen, lat, flg);
            chk(V_TAG[v], "cmp", cmp_o, V_CMP[v]);
            chk("R9", "flags", {16'd0, flags_o}, {16'd0, V_FLG[v]});
            chk("R9", "irq seen", {31'd0, seen}, {31'd0, V_FLG[v][7]});
            if (V_FLG[v][7]) chk("R3", "latency", lat, V_LOST[v]);
        end

        // R10 tick with all enables clear disables the channel
        {per_en_i, alm_en_i, upd_en_i} = 3'b000;
        count_i = 32'd14830;
        @(negedge clk);
        do_tick(seen, lat, flg);
        chk("R10", "cmp_en", {31'd0, cmp_en_o}, 32'd0);
        chk("R10", "irq seen", {31'd0, seen}, 32'd0);
        chk("R10", "cmp hold", cmp_o, 32'd14824);
        // R10 ticks ignored while disabled
        count_i = 32'd20000;
        do_tick(seen, lat, flg);
        chk("R10", "cmp still", cmp_o, 32'd14824);
        chk("R10", "flags kept", {16'd0, flags_o}, 32'h01F0);

        // R2 re-arm near counter wrap
        count_i = 32'hFFFF_FF00; upd_en_i = 1'b1;
        @(negedge clk);
        chk("R2", "wrap arm cmp", cmp_o, 32'h0000_0300);
        chk("R2", "wrap arm en", {31'd0, cmp_en_o}, 32'd1);

        // R3 signed ahead test across wrap
        count_i = 32'hFFFF_FF10; sec_i = 8'd10;
        @(negedge clk);
        do_tick(seen, lat, flg);
        chk("R3", "wrap cmp", cmp_o, 32'h0000_0700);
        chk("R3", "wrap latency", lat, 0);
        chk("R4", "wrap flags", {16'd0, flg}, 32'h0190);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule